// File: doc/BRIEF.md
# Rectangle Fill and Vertical Scroll Pixel Engine

This block is a small drawing engine for a linear frame buffer of 32-bit pixels. Software sets it up through a narrow register write port. It chooses a command code, gives box coordinates and a size, and then writes the width register, which starts the work. The engine then walks the box one pixel at a time over a synchronous pixel memory port. It fetches the old pixel at each destination, combines it with the new value through a raster-operation stage, and writes the result back.

Two commands are supported. A solid fill paints the foreground colour over a box. A vertical scroll moves a box to another row position in the same column range. When the two boxes overlap, the scroll picks its row order so that no source row is overwritten before it has been read. Each line is a fixed 8192 bytes, so a pixel's byte address is `row * 8192 + column * 4`. While a command runs, `busy` is high and `reg_ready` is low. Register writes made in that time are dropped.

Top module: `rfs_engine`

## Requirements
- R1: After reset, `busy` and `mem_req` are low, `reg_ready` is high, and the raster-operation register holds 0x83, so a fill with no raster-operation write stores the plain foreground colour.
- R2: Command code 0x08 (register 0) runs a fill. Every pixel in the box with origin row (register 3), origin column (register 4), height (register 7) and width (register 8) receives the foreground value (register 2, red in bits 7:0, green in 15:8, blue in 23:16), and no pixel outside the box changes.
- R3: Every memory access uses byte address `row * 8192 + column * 4`, so the two low address bits are zero.
- R4: Raster-operation register 1 selects how the new value N and the old pixel O are combined: 0x83 stores N, 0x85 stores O, 0x86 stores N XOR O. Any other code stores N.
- R5: Command code 0x0B runs a scroll. Source row is register 3, source column register 4, destination row register 5 and destination column register 6. Each destination pixel becomes the raster-operation result of the matching source pixel and the old destination pixel.
- R6: A scroll whose destination column differs from its source column, or whose destination row equals its source row, is ignored. No memory access is made and `busy` stays low.
- R7: Command codes other than 0x08 and 0x0B are ignored when the width register is written. No memory access is made.
- R8: `busy` rises in the cycle after the width write that starts a command. Each pixel is read and then written at the same address. `busy` falls after the last write. A fill keeps `busy` high for 2 cycles per pixel and a scroll for 3 cycles per pixel.
- R9: A scroll whose destination row is greater than its source row works from the bottom row upward. Any other scroll works top-down. An overlapping move copies the source exactly.
- R10: While `busy` is high, `reg_ready` is low and register writes have no effect on any register.
- R11: Writing a width of zero, or starting with a height of zero, starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | High when register writes are accepted |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Pixel memory access this cycle |
| mem_we | output | 1 | Access is a write (else a read, data next cycle) |
| mem_addr | output | 25 | Pixel byte address |
| mem_wdata | output | 32 | Pixel write data |
| mem_rdata | input | 32 | Pixel read data, one cycle after the read request |

## Verification
The bench aims at overlapping scrolls in both directions. If the row order is wrong, source rows are smeared across the destination, and the first row written shows the wrong order. It runs scrolls that should be rejected and reserved command codes. A design that launched them anyway would change pixels and raise `busy`. Register writes are tried during a running fill. A design that accepted them would paint the next box in the new colour or with the new raster operation. Exact busy lengths and fills near the column limit expose dropped or repeated pixels and a wrong line pitch.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // register indices on the write port
  localparam logic [3:0] A_DRAWOP = 4'd0;
  localparam logic [3:0] A_ROP    = 4'd1;
  localparam logic [3:0] A_FG     = 4'd2;
  localparam logic [3:0] A_SRC_Y  = 4'd3;
  localparam logic [3:0] A_SRC_X  = 4'd4;
  localparam logic [3:0] A_DST_Y  = 4'd5;
  localparam logic [3:0] A_DST_X  = 4'd6;
  localparam logic [3:0] A_HEIGHT = 4'd7;
  localparam logic [3:0] A_WIDTH  = 4'd8;

  // command codes
  localparam logic [7:0] OP_FILL    = 8'h08;
  localparam logic [7:0] OP_VSCROLL = 8'h0B;

  // raster operation codes
  localparam logic [7:0] ROP_NEW = 8'h83;
  localparam logic [7:0] ROP_OLD = 8'h85;
  localparam logic [7:0] ROP_XOR = 8'h86;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_SRC = 2'd1,
    ST_RD_DST = 2'd2,
    ST_WR     = 2'd3
  } walk_state_e;

endpackage

// File: rtl/rfs_regs.sv
module rfs_regs
  import rfs_pkg::*;
#(
  parameter int X_W = 11,
  parameter int Y_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           busy,
  output logic           launch,
  output logic           is_copy,
  output logic [X_W-1:0] col0,
  output logic [Y_W-1:0] src_row,
  output logic [Y_W-1:0] dst_row,
  output logic [X_W-1:0] launch_width,
  output logic [Y_W-1:0] height,
  output logic [31:0]    fg,
  output logic [7:0]     rop
);

  logic [7:0]     op_q, rop_q;
  logic [31:0]    fg_q;
  logic [Y_W-1:0] sy_q, dy_q, h_q;
  logic [X_W-1:0] sx_q, dx_q;

  logic wr_ok;
  logic en_op, en_rop, en_fg, en_sy, en_sx, en_dy, en_dx, en_h, en_w;

  assign wr_ok  = reg_we & ~busy;
  assign en_op  = wr_ok & (reg_addr == A_DRAWOP);
  assign en_rop = wr_ok & (reg_addr == A_ROP);
  assign en_fg  = wr_ok & (reg_addr == A_FG);
  assign en_sy  = wr_ok & (reg_addr == A_SRC_Y);
  assign en_sx  = wr_ok & (reg_addr == A_SRC_X);
  assign en_dy  = wr_ok & (reg_addr == A_DST_Y);
  assign en_dx  = wr_ok & (reg_addr == A_DST_X);
  assign en_h   = wr_ok & (reg_addr == A_HEIGHT);
  assign en_w   = wr_ok & (reg_addr == A_WIDTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      rop_q <= ROP_NEW;
      fg_q  <= '0;
      sy_q  <= '0;
      sx_q  <= '0;
      dy_q  <= '0;
      dx_q  <= '0;
      h_q   <= '0;
    end else begin
      if (en_op)  op_q  <= reg_wdata[7:0];
      if (en_rop) rop_q <= reg_wdata[7:0];
      if (en_fg)  fg_q  <= reg_wdata;
      if (en_sy)  sy_q  <= reg_wdata[Y_W-1:0];
      if (en_sx)  sx_q  <= reg_wdata[X_W-1:0];
      if (en_dy)  dy_q  <= reg_wdata[Y_W-1:0];
      if (en_dx)  dx_q  <= reg_wdata[X_W-1:0];
      if (en_h)   h_q   <= reg_wdata[Y_W-1:0];
    end
  end

  // launch decode: the width write itself starts the command
  logic fill_ok, copy_ok, geom_ok;
  assign launch_width = reg_wdata[X_W-1:0];
  assign geom_ok = (launch_width != '0) && (h_q != '0);
  assign fill_ok = (op_q == OP_FILL);
  assign copy_ok = (op_q == OP_VSCROLL) && (dx_q == sx_q) && (dy_q != sy_q);
  assign launch  = en_w & geom_ok & (fill_ok | copy_ok);

  assign is_copy = (op_q == OP_VSCROLL);
  assign col0    = sx_q;
  assign src_row = sy_q;
  assign dst_row = is_copy ? dy_q : sy_q;
  assign height  = h_q;
  assign fg      = fg_q;
  assign rop     = rop_q;

endmodule

// File: rtl/rfs_walk.sv
module rfs_walk
  import rfs_pkg::*;
#(
  parameter int X_W    = 11,
  parameter int Y_W    = 12,
  parameter int ADDR_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              is_copy,
  input  logic [X_W-1:0]    col0,
  input  logic [Y_W-1:0]    src_row,
  input  logic [Y_W-1:0]    dst_row,
  input  logic [X_W-1:0]    width,
  input  logic [Y_W-1:0]    height,
  input  logic [31:0]       fg,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       new_pix
);

  walk_state_e    state_q, state_d;
  logic           cpy_q, cpy_d, up_q, up_d;
  logic [X_W-1:0] x0_q, x0_d, w_q, w_d, cx_q, cx_d, cols_q, cols_d;
  logic [Y_W-1:0] sr_q, sr_d, dr_q, dr_d, rows_q, rows_d;
  logic [31:0]    src_q;
  logic           src_en;

  always_comb begin
    state_d = state_q;
    cpy_d   = cpy_q;
    up_d    = up_q;
    x0_d    = x0_q;
    w_d     = w_q;
    cx_d    = cx_q;
    cols_d  = cols_q;
    sr_d    = sr_q;
    dr_d    = dr_q;
    rows_d  = rows_q;
    src_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (launch) begin
          cpy_d  = is_copy;
          up_d   = is_copy && (dst_row > src_row);
          x0_d   = col0;
          cx_d   = col0;
          w_d    = width;
          cols_d = width - 1'b1;
          rows_d = height - 1'b1;
          sr_d   = up_d ? src_row + height - 1'b1 : src_row;
          dr_d   = up_d ? dst_row + height - 1'b1 : dst_row;
          state_d = is_copy ? ST_RD_SRC : ST_RD_DST;
        end
      end
      ST_RD_SRC: state_d = ST_RD_DST;
      ST_RD_DST: begin
        src_en  = cpy_q;
        state_d = ST_WR;
      end
      ST_WR: begin
        if (cols_q != '0) begin
          cx_d    = cx_q + 1'b1;
          cols_d  = cols_q - 1'b1;
          state_d = cpy_q ? ST_RD_SRC : ST_RD_DST;
        end else if (rows_q != '0) begin
          cx_d    = x0_q;
          cols_d  = w_q - 1'b1;
          rows_d  = rows_q - 1'b1;
          sr_d    = up_q ? sr_q - 1'b1 : sr_q + 1'b1;
          dr_d    = up_q ? dr_q - 1'b1 : dr_q + 1'b1;
          state_d = cpy_q ? ST_RD_SRC : ST_RD_DST;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cpy_q   <= 1'b0;
      up_q    <= 1'b0;
      x0_q    <= '0;
      w_q     <= '0;
      cx_q    <= '0;
      cols_q  <= '0;
      sr_q    <= '0;
      dr_q    <= '0;
      rows_q  <= '0;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      cpy_q   <= cpy_d;
      up_q    <= up_d;
      x0_q    <= x0_d;
      w_q     <= w_d;
      cx_q    <= cx_d;
      cols_q  <= cols_d;
      sr_q    <= sr_d;
      dr_q    <= dr_d;
      rows_q  <= rows_d;
      if (src_en) src_q <= mem_rdata;
    end
  end

  logic [Y_W-1:0] row_sel;
  assign row_sel  = (state_q == ST_RD_SRC) ? sr_q : dr_q;
  assign mem_addr = {row_sel, cx_q, 2'b00};
  assign busy     = (state_q != ST_IDLE);
  assign mem_req  = busy;
  assign mem_we   = (state_q == ST_WR);
  assign new_pix  = cpy_q ? src_q : fg;

endmodule

// File: rtl/rfs_rop.sv
module rfs_rop
  import rfs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        rop,
  input  logic [DATA_W-1:0] new_val,
  input  logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    case (rop)
      ROP_OLD: result = old_val;
      ROP_XOR: result = new_val ^ old_val;
      default: result = new_val;
    endcase
  end

endmodule

// File: rtl/rfs_engine.sv
module rfs_engine #(
  parameter int PITCH_BYTES = 8192,
  parameter int Y_W         = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 reg_we,
  input  logic [3:0]                           reg_addr,
  input  logic [31:0]                          reg_wdata,
  output logic                                 reg_ready,
  output logic                                 busy,
  output logic                                 mem_req,
  output logic                                 mem_we,
  output logic [Y_W+$clog2(PITCH_BYTES)-1:0]   mem_addr,
  output logic [31:0]                          mem_wdata,
  input  logic [31:0]                          mem_rdata
);

  localparam int PITCH_LOG2 = $clog2(PITCH_BYTES);
  localparam int X_W        = PITCH_LOG2 - 2;
  localparam int ADDR_W     = Y_W + PITCH_LOG2;

  logic           launch, is_copy;
  logic [X_W-1:0] col0, launch_width;
  logic [Y_W-1:0] src_row, dst_row, height;
  logic [31:0]    fg, new_pix;
  logic [7:0]     rop;

  rfs_regs #(.X_W(X_W), .Y_W(Y_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .launch(launch), .is_copy(is_copy),
    .col0(col0), .src_row(src_row), .dst_row(dst_row),
    .launch_width(launch_width), .height(height), .fg(fg), .rop(rop)
  );

  rfs_walk #(.X_W(X_W), .Y_W(Y_W), .ADDR_W(ADDR_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .is_copy(is_copy),
    .col0(col0), .src_row(src_row), .dst_row(dst_row), .width(launch_width),
    .height(height), .fg(fg), .mem_rdata(mem_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .new_pix(new_pix)
  );

  rfs_rop #(.DATA_W(32)) rop_i (
    .rop(rop), .new_val(new_pix), .old_val(mem_rdata), .result(mem_wdata)
  );

  assign reg_ready = ~busy;

endmodule

// File: rtl/rfs_engine_chk.sv
module rfs_engine_chk #(
  parameter int ADDR_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  // R8: no memory traffic while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R8: a command only begins after a width register write
  p_start_on_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && (reg_addr == 4'd8)));

  // R8: each write follows a read of the same address
  p_rmw_same_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_req && !mem_we) && (mem_addr == $past(mem_addr))));

  // R8: a command ends right after a pixel write
  p_end_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_we));

  // R3: pixel addresses are word aligned
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

endmodule

bind rfs_engine rfs_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/rfs_engine_tb_top.sv
module rfs_engine_tb_top;

  localparam int ADDR_W = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              reg_we;
  logic [3:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic              reg_ready, busy, mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata;

  rfs_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] fb  [64][64];
  logic [31:0] rf  [64][64];
  logic [31:0] tmp [64][64];
  int vec_n = 0, bad_n = 0, bad_addr = 0, wr_in_cmd = 0, first_wr_y = -1;

  wire [11:0] a_y = mem_addr[24:13];
  wire [10:0] a_x = mem_addr[12:2];

  // pixel memory model: one-cycle read latency
  always @(posedge clk) begin
    if (!busy) wr_in_cmd <= 0;
    else if (mem_we) wr_in_cmd <= wr_in_cmd + 1;
    if (mem_req) begin
      if (a_y >= 64 || a_x >= 64 || mem_addr[1:0] != 2'b00) bad_addr <= bad_addr + 1;
      else if (mem_we) begin
        fb[a_y[5:0]][a_x[5:0]] <= mem_wdata;
        if (wr_in_cmd == 0) first_wr_y <= int'(a_y);
      end else mem_rdata <= fb[a_y[5:0]][a_x[5:0]];
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vec_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp_fb(input string req);
    int mism = 0;
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 64; x++)
        if (fb[y][x] !== rf[y][x]) mism++;
    chk({req, " frame buffer mismatching pixels"}, mism, 0);
  endtask

  function automatic logic [31:0] rop_f(input logic [7:0] r, input logic [31:0] n, input logic [31:0] o);
    if (r == 8'h85) return o;
    if (r == 8'h86) return n ^ o;
    return n;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 50000) begin n++; @(negedge clk); end
  endtask

  task automatic ref_fill(input int x0, input int y0, input int w, input int h,
                          input logic [31:0] c, input logic [7:0] r);
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++)
        rf[y][x] = rop_f(r, c, rf[y][x]);
  endtask

  task automatic ref_copy(input int x0, input int sy, input int dy, input int w, input int h,
                          input logic [7:0] r);
    for (int y = 0; y < 64; y++) for (int x = 0; x < 64; x++) tmp[y][x] = rf[y][x];
    for (int i = 0; i < h; i++)
      for (int x = x0; x < x0 + w; x++)
        rf[dy + i][x] = rop_f(r, tmp[sy + i][x], rf[dy + i][x]);
  endtask

  // fill: command, origin row, origin column, height, width
  task automatic do_fill(input string req, input int x0, input int y0, input int w, input int h,
                         input logic [31:0] c, input logic [7:0] r);
    int n;
    wr(0, 32'h08); wr(2, c); wr(3, y0); wr(4, x0); wr(7, h); wr(8, w);
    chk({req, " R8 busy after width write"}, busy, 1'b1);
    wait_idle(n);
    chk({req, " R8 fill busy cycles"}, n, 2 * w * h);
    ref_fill(x0, y0, w, h, c, r);
    cmp_fb(req);
  endtask

  task automatic do_copy(input string req, input int x0, input int sy, input int dy,
                         input int w, input int h, input int exp_first);
    int n;
    wr(0, 32'h0B); wr(3, sy); wr(4, x0); wr(5, dy); wr(6, x0); wr(7, h); wr(8, w);
    chk({req, " R8 busy after width write"}, busy, 1'b1);
    wait_idle(n);
    chk({req, " R8 scroll busy cycles"}, n, 3 * w * h);
    chk({req, " R9 first destination row written"}, first_wr_y, exp_first);
    ref_copy(x0, sy, dy, w, h, 8'h83);
    cmp_fb(req);
  endtask

  task automatic t_reset;
    chk("R1 busy low after reset", busy, 1'b0);
    chk("R1 reg_ready high after reset", reg_ready, 1'b1);
    chk("R1 no memory request after reset", mem_req, 1'b0);
  endtask

  task automatic t_fill_basic;
    do_fill("R1 R2 fill with reset raster op", 2, 3, 5, 4, 32'h00AABBCC, 8'h83);
    do_fill("R2 R3 fill at column limit", 58, 60, 6, 4, 32'h00123456, 8'h83);
  endtask

  task automatic t_rop;
    wr(1, 32'h86);
    do_fill("R4 xor raster op", 1, 1, 7, 3, 32'h00FF00FF, 8'h86);
    wr(1, 32'h85);
    do_fill("R4 keep-old raster op", 1, 1, 7, 3, 32'h00000001, 8'h85);
    wr(1, 32'h42);
    do_fill("R4 other code stores new", 20, 40, 3, 3, 32'h00C0FFEE, 8'h42);
    wr(1, 32'h83);
  endtask

  task automatic t_copy_down;
    do_copy("R5 R9 overlapping move down", 5, 10, 12, 4, 6, 12 + 6 - 1);
  endtask

  task automatic t_copy_up;
    do_copy("R5 R9 overlapping move up", 40, 30, 27, 5, 8, 27);
  endtask

  task automatic t_copy_reject;
    wr(0, 32'h0B); wr(3, 10); wr(4, 5); wr(5, 20); wr(6, 6); wr(7, 2); wr(8, 2);
    chk("R6 column mismatch not started", busy, 1'b0);
    wr(5, 10); wr(6, 5); wr(8, 2);
    chk("R6 equal rows not started", busy, 1'b0);
    repeat (3) @(negedge clk);
    cmp_fb("R6 rejected scrolls");
  endtask

  task automatic t_reserved;
    wr(0, 32'h05); wr(2, 32'h11111111); wr(3, 0); wr(4, 0); wr(7, 4); wr(8, 4);
    chk("R7 reserved code 0x05 not started", busy, 1'b0);
    wr(0, 32'h0A); wr(8, 4);
    chk("R7 reserved code 0x0A not started", busy, 1'b0);
    repeat (3) @(negedge clk);
    cmp_fb("R7 reserved codes");
  endtask

  task automatic t_holdoff;
    int n;
    do_fill("R10 setup fill", 10, 50, 8, 4, 32'h00ABCDEF, 8'h83);
    wr(0, 32'h08); wr(3, 44); wr(4, 30); wr(7, 5); wr(8, 8);
    chk("R10 reg_ready low while busy", reg_ready, 1'b0);
    wr(2, 32'h00999999);
    wr(1, 32'h86);
    wait_idle(n);
    ref_fill(30, 44, 8, 5, 32'h00ABCDEF, 8'h83);
    cmp_fb("R10 first fill");
    wr(3, 2); wr(4, 50); wr(7, 3); wr(8, 3);
    wait_idle(n);
    ref_fill(50, 2, 3, 3, 32'h00ABCDEF, 8'h83);
    cmp_fb("R10 writes during busy dropped");
  endtask

  task automatic t_zero;
    wr(0, 32'h08); wr(3, 0); wr(4, 0); wr(7, 3); wr(8, 0);
    chk("R11 zero width not started", busy, 1'b0);
    wr(7, 0); wr(8, 3);
    chk("R11 zero height not started", busy, 1'b0);
    repeat (3) @(negedge clk);
    cmp_fb("R11 zero size");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
  endtask

  initial begin
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 64; x++) begin
        fb[y][x] = 32'h0100_0000 + y * 256 + x;
        rf[y][x] = 32'h0100_0000 + y * 256 + x;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill_basic;
    t_rop;
    t_copy_down;
    t_copy_up;
    t_copy_reject;
    t_reserved;
    t_holdoff;
    t_zero;
    chk("R3 out-of-range or misaligned accesses", bad_addr, 0);
    summary;
    $finish;
  end

  initial begin
    #(8 * 150000);
    bad_n++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    summary;
    $finish;
  end

endmodule